// File: doc/BRIEF.md
# Multi-Class Physical Register Free List

This block holds the free physical register tags for the rename stage of an out-of-order core. There are six register classes: integer, floating point, vector, vector element, predicate and condition code. Each class has its own first-in first-out pool. Every class has an allocate request line. When a request is granted, the oldest free tag of that class comes out one cycle later.

Registers are returned through one release interface. It carries from one to `BURST_N` lanes, and each lane has a class code and a tag. The block steers an accepted release to the pool named by the class code. It rejects a malformed release as a whole and raises an error pulse for it. The block also tracks which registers are allocated, so a tag that is already free cannot be returned a second time.

Tags use one numbering for all classes. Class `c` owns tags `c*POOL_DEPTH` to `c*POOL_DEPTH+POOL_DEPTH-1`. After reset, the lowest `RSV_PER_CLASS` tags of each class are taken by the initial architectural mappings. The rest of each class's tags wait in its pool in ascending order.

Top module: `regfl_top`

## Requirements
- R1: After reset, each class has `POOL_DEPTH-RSV_PER_CLASS` free tags, queued in ascending order from `c*POOL_DEPTH+RSV_PER_CLASS`. All error outputs are low and `alloc_vld_o` is zero.
- R2: An allocate request on a class with free tags pops that pool's oldest tag. The tag appears on `alloc_tag_o` together with `alloc_vld_o` in the next cycle. Released tags are appended at the tail of the pool.
- R3: Class codes are 0 integer, 1 floating point, 2 vector, 3 vector element, 4 predicate and 5 condition code. An accepted release is written into the pool given by lane 0's class code and into no other pool.
- R4: A release of `rel_cnt_i` lanes writes all of those lanes in lane order when it is accepted. If the class codes of lane 0 and lane `rel_cnt_i-1` differ, `err_mixed_o` pulses in the next cycle and nothing is written.
- R5: A release is rejected as malformed if any of these holds: the class code is 6 or 7; a lane's tag lies outside its class's range; or `rel_cnt_i` is 0 or above `BURST_N`. A malformed release pulses `err_cls_o` in the next cycle and changes no pool.
- R6: An allocate request on an empty pool pulses `err_empty_o` in the next cycle. It gives `alloc_vld_o` low and a zero tag for that class, and it pops nothing.
- R7: `free_cnt_o` gives each class's free count, and `has_free_o` is high exactly when that count is non-zero. Both track the result of the previous cycle's requests.
- R8: A release is a double free if it returns a tag that is already free, or names the same tag in two lanes. A double free pulses `err_dfree_o`, is dropped whole, and leaves every count unchanged.
- R9: When an allocate and a single-lane release of the same class happen in one cycle, that class's count does not change. The popped tag is the head that was there before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | NCLS | Allocate request, one bit per class |
| alloc_vld_o | output | NCLS | Granted allocation, one cycle after the request |
| alloc_tag_o | output | NCLS*TAG_W | Popped tag for each class, zero when not granted |
| rel_vld_i | input | 1 | Release request |
| rel_cnt_i | input | NW | Number of lanes used, from 1 to BURST_N |
| rel_cls_i | input | BURST_N*3 | Class code of each lane |
| rel_tag_i | input | BURST_N*TAG_W | Tag of each lane |
| free_cnt_o | output | NCLS*CNT_W | Free count of each class |
| has_free_o | output | NCLS | Pool of each class is non-empty |
| err_mixed_o | output | 1 | Pulse: first and last lane classes differ |
| err_cls_o | output | 1 | Pulse: malformed release |
| err_dfree_o | output | 1 | Pulse: double free |
| err_empty_o | output | 1 | Pulse: allocate request on an empty pool |

## Verification
A corrupted read or write pointer shows on the very next grant, as a tag that is out of order or belongs to a different class. A wrong count shows on `free_cnt_o` and `has_free_o` one cycle after the request that caused it. A stale allocated-bit is less direct. It shows up only when that tag is later released, either as a double free that should not be reported or as a duplicate that gets accepted. For that reason the scenarios release tags that were allocated earlier and also tags that are still free, and in both cases they check the error pulse and the counts one cycle later.

// File: rtl/regfl_pkg.sv
package regfl_pkg;
  localparam int NCLS  = 6;
  localparam int CLS_W = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 3'd0,
    CLS_FP    = 3'd1,
    CLS_VEC   = 3'd2,
    CLS_VELEM = 3'd3,
    CLS_PRED  = 3'd4,
    CLS_CC    = 3'd5
  } reg_cls_e;
endpackage

// File: rtl/regfl_pool.sv
module regfl_pool #(
  parameter int DEPTH   = 8,
  parameter int TAG_W   = 6,
  parameter int RSV     = 2,
  parameter int BASE    = 0,
  parameter int BURST_N = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int NW     = $clog2(BURST_N + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pop_i,
  input  logic                     push_i,
  input  logic [NW-1:0]            push_n_i,
  input  logic [BURST_N*TAG_W-1:0] push_tags_i,
  output logic [TAG_W-1:0]         head_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     nonempty_o
);
  logic [TAG_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push_i) cnt_d = cnt_d + CNT_W'(push_n_i);
    if (pop_i)  cnt_d = cnt_d - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < DEPTH - RSV) ? TAG_W'(BASE + RSV + i) : '0;
      rd_q       <= '0;
      wr_q       <= PTR_W'((DEPTH - RSV) % DEPTH);
      cnt_q      <= CNT_W'(DEPTH - RSV);
      nonempty_q <= (DEPTH - RSV) != 0;
    end else begin
      if (pop_i) rd_q <= rd_q + PTR_W'(1);
      if (push_i) begin
        for (int k = 0; k < BURST_N; k++)
          if (k < int'(push_n_i))
            mem_q[wr_q + PTR_W'(k)] <= push_tags_i[k*TAG_W +: TAG_W];
        wr_q <= wr_q + PTR_W'(push_n_i);
      end
      cnt_q      <= cnt_d;
      nonempty_q <= cnt_d != '0;
    end
  end

  logic nonempty_q;
  assign head_o     = mem_q[rd_q];
  assign cnt_o      = cnt_q;
  assign nonempty_o = nonempty_q;

  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)) else $error("pool overfilled"); // R8
  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0) else $error("pop on empty pool"); // R6
  AST_SWAP_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_i && push_n_i == NW'(1)) |=> $stable(cnt_q)) else $error("swap moved count"); // R9
  AST_HAS_FREE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonempty_q == (cnt_q != '0)) else $error("has_free mismatch"); // R7
endmodule

// File: rtl/regfl_rel_check.sv
module regfl_rel_check
  import regfl_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RSV     = 2,
  parameter int TAG_W   = 6,
  parameter int BURST_N = 4,
  localparam int NW     = $clog2(BURST_N + 1),
  localparam int TOTAL  = NCLS * DEPTH,
  localparam int OFF_W  = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rel_vld_i,
  input  logic [NW-1:0]            rel_cnt_i,
  input  logic [BURST_N*CLS_W-1:0] rel_cls_i,
  input  logic [BURST_N*TAG_W-1:0] rel_tag_i,
  input  logic [NCLS-1:0]          pop_i,
  input  logic [NCLS*TAG_W-1:0]    pop_tag_i,
  output logic [NCLS-1:0]          push_o,
  output logic                     err_mixed_o,
  output logic                     err_cls_o,
  output logic                     err_dfree_o
);
  logic [TOTAL-1:0] busy_q;
  logic [CLS_W-1:0] cls0, clsl;
  logic cnt_ok, mix, bad, dfree, ok;

  always_comb begin
    cnt_ok = (rel_cnt_i != '0) && (int'(rel_cnt_i) <= BURST_N);
    cls0   = rel_cls_i[CLS_W-1:0];
    clsl   = cls0;
    for (int k = 0; k < BURST_N; k++)
      if (k + 1 == int'(rel_cnt_i)) clsl = rel_cls_i[k*CLS_W +: CLS_W];
    mix   = cls0 != clsl;
    bad   = int'(cls0) >= NCLS;
    dfree = 1'b0;
    for (int k = 0; k < BURST_N; k++) begin
      if (k < int'(rel_cnt_i)) begin
        // tag must sit in the range owned by the lane-0 class
        if (int'(rel_tag_i[k*TAG_W +: TAG_W] >> OFF_W) != int'(cls0)) bad = 1'b1;
        else if (int'(rel_tag_i[k*TAG_W +: TAG_W]) < TOTAL &&
                 !busy_q[rel_tag_i[k*TAG_W +: TAG_W]]) dfree = 1'b1;
        for (int j = 0; j < k; j++)
          if (rel_tag_i[j*TAG_W +: TAG_W] == rel_tag_i[k*TAG_W +: TAG_W]) dfree = 1'b1;
      end
    end
    ok          = rel_vld_i && cnt_ok && !mix && !bad && !dfree;
    push_o      = ok ? (NCLS'(1) << cls0) : '0;
    err_cls_o   = rel_vld_i && (!cnt_ok || bad);
    err_mixed_o = rel_vld_i && cnt_ok && mix;
    err_dfree_o = rel_vld_i && cnt_ok && !mix && !bad && dfree;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TOTAL; i++) busy_q[i] <= (i % DEPTH) < RSV;
    end else begin
      for (int c = 0; c < NCLS; c++)
        if (pop_i[c]) busy_q[pop_tag_i[c*TAG_W +: TAG_W]] <= 1'b1;
      if (ok)
        for (int k = 0; k < BURST_N; k++)
          if (k < int'(rel_cnt_i)) busy_q[rel_tag_i[k*TAG_W +: TAG_W]] <= 1'b0;
    end
  end

  AST_RELEASE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok |=> !busy_q[$past(rel_tag_i[TAG_W-1:0])]) else $error("released tag still busy"); // R8

  for (genvar c = 0; c < NCLS; c++) begin : g_pop_chk
    AST_POP_WAS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i[c] |-> !busy_q[pop_tag_i[c*TAG_W +: TAG_W]]) else $error("popped a busy tag"); // R8
  end
endmodule

// File: rtl/regfl_top.sv
module regfl_top
  import regfl_pkg::*;
#(
  parameter int POOL_DEPTH    = 8,
  parameter int RSV_PER_CLASS = 2,
  parameter int BURST_N       = 4,
  parameter int TAG_W         = 6,
  localparam int CNT_W        = $clog2(POOL_DEPTH + 1),
  localparam int NW           = $clog2(BURST_N + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NCLS-1:0]          alloc_req_i,
  output logic [NCLS-1:0]          alloc_vld_o,
  output logic [NCLS*TAG_W-1:0]    alloc_tag_o,
  input  logic                     rel_vld_i,
  input  logic [NW-1:0]            rel_cnt_i,
  input  logic [BURST_N*CLS_W-1:0] rel_cls_i,
  input  logic [BURST_N*TAG_W-1:0] rel_tag_i,
  output logic [NCLS*CNT_W-1:0]    free_cnt_o,
  output logic [NCLS-1:0]          has_free_o,
  output logic                     err_mixed_o,
  output logic                     err_cls_o,
  output logic                     err_dfree_o,
  output logic                     err_empty_o
);
  logic [NCLS-1:0]       pop, push;
  logic [NCLS*TAG_W-1:0] head;
  logic                  mixed_d, cls_d, dfree_d;

  assign pop = alloc_req_i & has_free_o;

  regfl_rel_check #(
    .DEPTH(POOL_DEPTH), .RSV(RSV_PER_CLASS), .TAG_W(TAG_W), .BURST_N(BURST_N)
  ) u_check (
    .clk_i, .rst_ni, .rel_vld_i, .rel_cnt_i, .rel_cls_i, .rel_tag_i,
    .pop_i(pop), .pop_tag_i(head), .push_o(push),
    .err_mixed_o(mixed_d), .err_cls_o(cls_d), .err_dfree_o(dfree_d)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_pool
    regfl_pool #(
      .DEPTH(POOL_DEPTH), .TAG_W(TAG_W), .RSV(RSV_PER_CLASS),
      .BASE(c * POOL_DEPTH), .BURST_N(BURST_N)
    ) u_pool (
      .clk_i, .rst_ni,
      .pop_i(pop[c]), .push_i(push[c]), .push_n_i(rel_cnt_i), .push_tags_i(rel_tag_i),
      .head_o(head[c*TAG_W +: TAG_W]),
      .cnt_o(free_cnt_o[c*CNT_W +: CNT_W]),
      .nonempty_o(has_free_o[c])
    );

    AST_VLD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_vld_o[c] |-> $past(alloc_req_i[c])) else $error("grant without request"); // R2
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_vld_o <= '0;
      alloc_tag_o <= '0;
      err_mixed_o <= 1'b0;
      err_cls_o   <= 1'b0;
      err_dfree_o <= 1'b0;
      err_empty_o <= 1'b0;
    end else begin
      alloc_vld_o <= pop;
      for (int c = 0; c < NCLS; c++)
        alloc_tag_o[c*TAG_W +: TAG_W] <= pop[c] ? head[c*TAG_W +: TAG_W] : '0;
      err_mixed_o <= mixed_d;
      err_cls_o   <= cls_d;
      err_dfree_o <= dfree_d;
      err_empty_o <= |(alloc_req_i & ~has_free_o);
    end
  end

  AST_EMPTY_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_empty_o |-> (alloc_vld_o != $past(alloc_req_i))) else $error("empty grant"); // R6
endmodule

// File: tb/test_regfl_top.sv
module test_regfl_top;
  import regfl_pkg::*;
  localparam int D = 8, RSV = 2, BN = 4, TW = 6;
  localparam int CW = $clog2(D + 1), NW = $clog2(BN + 1);

  logic clk = 0, rst_n = 0;
  logic [NCLS-1:0] alloc_req = '0, alloc_vld, has_free;
  logic [NCLS*TW-1:0] alloc_tag;
  logic rel_vld = 0;
  logic [NW-1:0] rel_cnt = '0;
  logic [BN*CLS_W-1:0] rel_cls = '0;
  logic [BN*TW-1:0] rel_tag = '0;
  logic [NCLS*CW-1:0] free_cnt;
  logic e_mix, e_cls, e_df, e_emp;
  int checks = 0, fails = 0;
  int exp_cnt [NCLS];

  always #5 clk = ~clk;

  regfl_top #(.POOL_DEPTH(D), .RSV_PER_CLASS(RSV), .BURST_N(BN), .TAG_W(TW)) i_regfl_top (
    .clk_i(clk), .rst_ni(rst_n), .alloc_req_i(alloc_req), .alloc_vld_o(alloc_vld),
    .alloc_tag_o(alloc_tag), .rel_vld_i(rel_vld), .rel_cnt_i(rel_cnt), .rel_cls_i(rel_cls),
    .rel_tag_i(rel_tag), .free_cnt_o(free_cnt), .has_free_o(has_free),
    .err_mixed_o(e_mix), .err_cls_o(e_cls), .err_dfree_o(e_df), .err_empty_o(e_emp));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    for (int c = 0; c < NCLS; c++) begin
      chk(int'(free_cnt[c*CW +: CW]) == exp_cnt[c], req, int'(free_cnt[c*CW +: CW]), exp_cnt[c]);
      chk(has_free[c] == (exp_cnt[c] != 0), {req, "/R7"}, int'(has_free[c]), int'(exp_cnt[c] != 0));
    end
  endtask

  task automatic set_lane(input int k, input int cls, input int tag);
    rel_cls[k*CLS_W +: CLS_W] = CLS_W'(cls);
    rel_tag[k*TW +: TW] = TW'(tag);
  endtask

  // drive a release in the current low phase, sample one cycle later
  task automatic release_n(input int n);
    rel_vld = 1; rel_cnt = NW'(n);
    @(negedge clk);
    rel_vld = 0; rel_cnt = '0; rel_cls = '0; rel_tag = '0;
  endtask

  task automatic alloc_one(input int c, input int exp_tag, input string req);
    alloc_req[c] = 1;
    @(negedge clk);
    alloc_req[c] = 0;
    chk(alloc_vld[c] == 1'b1, req, int'(alloc_vld[c]), 1);
    chk(int'(alloc_tag[c*TW +: TW]) == exp_tag, req, int'(alloc_tag[c*TW +: TW]), exp_tag);
    exp_cnt[c]--;
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCLS; c++) exp_cnt[c] = D - RSV;
    chk_counts("R1");
    chk({e_mix, e_cls, e_df, e_emp} == 4'b0, "R1", int'({e_mix, e_cls, e_df, e_emp}), 0);
    chk(alloc_vld == '0, "R1", int'(alloc_vld), 0);
  endtask

  task automatic t_order;
    alloc_one(CLS_INT, 2, "R1 first tag");
    alloc_one(CLS_INT, 3, "R2 fifo order");
    chk_counts("R2");
  endtask

  task automatic t_steer;
    set_lane(0, CLS_INT, 2); release_n(1); exp_cnt[CLS_INT]++;
    set_lane(0, CLS_FP, 8);  release_n(1); exp_cnt[CLS_FP]++;
    chk(!e_cls && !e_df && !e_mix, "R3 no error", int'({e_mix, e_cls, e_df}), 0);
    chk_counts("R3");
  endtask

  task automatic t_drain_empty;
    alloc_one(CLS_INT, 4, "R2");
    alloc_one(CLS_INT, 5, "R2");
    alloc_one(CLS_INT, 6, "R2");
    alloc_one(CLS_INT, 7, "R2");
    alloc_one(CLS_INT, 2, "R2 tail append");
    chk_counts("R7 empty");
    alloc_req[CLS_INT] = 1;
    @(negedge clk);
    alloc_req[CLS_INT] = 0;
    chk(e_emp == 1'b1, "R6 err_empty", int'(e_emp), 1);
    chk(alloc_vld[CLS_INT] == 1'b0, "R6 no grant", int'(alloc_vld[CLS_INT]), 0);
    chk(alloc_tag[CLS_INT*TW +: TW] == '0, "R6 zero tag", int'(alloc_tag[CLS_INT*TW +: TW]), 0);
    chk_counts("R6");
  endtask

  task automatic t_swap;
    alloc_one(CLS_CC, 42, "R9 setup");
    alloc_req[CLS_CC] = 1;
    set_lane(0, CLS_CC, 42);
    rel_vld = 1; rel_cnt = NW'(1);
    @(negedge clk);
    alloc_req = '0; rel_vld = 0; rel_cnt = '0; rel_cls = '0; rel_tag = '0;
    chk(int'(alloc_tag[CLS_CC*TW +: TW]) == 43, "R9 old head", int'(alloc_tag[CLS_CC*TW +: TW]), 43);
    chk_counts("R9 count held");
  endtask

  task automatic t_burst;
    alloc_one(CLS_VEC, 18, "R2");
    alloc_one(CLS_VEC, 19, "R2");
    alloc_one(CLS_VEC, 20, "R2");
    set_lane(0, CLS_VEC, 20); set_lane(1, CLS_VEC, 18); set_lane(2, CLS_VEC, 19);
    release_n(3); exp_cnt[CLS_VEC] += 3;
    chk(!e_mix && !e_cls && !e_df, "R4 burst ok", int'({e_mix, e_cls, e_df}), 0);
    chk_counts("R4 burst");
    alloc_one(CLS_VEC, 21, "R4");
    alloc_one(CLS_VEC, 22, "R4");
    alloc_one(CLS_VEC, 23, "R4");
    alloc_one(CLS_VEC, 20, "R4 lane order");
    alloc_one(CLS_VEC, 18, "R4 lane order");
  endtask

  task automatic t_mixed;
    alloc_one(CLS_FP, 10, "R4 setup");
    set_lane(0, CLS_FP, 10); set_lane(1, CLS_PRED, 34);
    release_n(2);
    chk(e_mix == 1'b1, "R4 err_mixed", int'(e_mix), 1);
    chk_counts("R4 mixed dropped");
    set_lane(0, CLS_FP, 10); release_n(1); exp_cnt[CLS_FP]++;
    chk(e_df == 1'b0, "R4 tag not written", int'(e_df), 0);
    chk_counts("R4");
  endtask

  task automatic t_unknown;
    set_lane(0, 6, 2); release_n(1);
    chk(e_cls == 1'b1, "R5 code 6", int'(e_cls), 1);
    set_lane(0, 7, 2); release_n(1);
    chk(e_cls == 1'b1, "R5 code 7", int'(e_cls), 1);
    set_lane(0, CLS_VELEM, 20); release_n(1);
    chk(e_cls == 1'b1, "R5 tag range", int'(e_cls), 1);
    set_lane(0, CLS_INT, 3); release_n(0);
    chk(e_cls == 1'b1, "R5 zero count", int'(e_cls), 1);
    set_lane(0, CLS_INT, 3); release_n(5);
    chk(e_cls == 1'b1, "R5 count above burst", int'(e_cls), 1);
    chk_counts("R5 no change");
  endtask

  task automatic t_dfree;
    set_lane(0, CLS_VELEM, 30); release_n(1);
    chk(e_df == 1'b1, "R8 free tag", int'(e_df), 1);
    set_lane(0, CLS_VEC, 21); set_lane(1, CLS_VEC, 21); release_n(2);
    chk(e_df == 1'b1, "R8 duplicate lanes", int'(e_df), 1);
    chk_counts("R8 dropped");
    set_lane(0, CLS_VEC, 21); release_n(1); exp_cnt[CLS_VEC]++;
    chk(e_df == 1'b0, "R8 legal release", int'(e_df), 0);
    chk_counts("R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_steer();
    t_drain_empty();
    t_swap();
    t_burst();
    t_mixed();
    t_unknown();
    t_dfree();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule